// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Slave

This block terminates a narrow serial management bus and turns each request frame into a single access on a parallel register port. The bus master raises a request strobe and, while it is high, places two bits per clock on an input lane. The first beat names the operation and the lowest address bit. The rest of the 17-bit address and, for writes, the data word follow two bits at a time, lowest bits first.

A completed write produces one write-enable pulse carrying the whole address and data word, followed by a one-cycle acknowledge. A completed read produces one read strobe. The returned word is then shifted out on a two-bit output lane, lowest pair first, with acknowledge high on every data beat. The word width (32 or 8 bits) is a parameter. A frame cut short by an early drop of the request is discarded without a register access. Request activity during a response is ignored.

Top module: `sbus2_slave`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ack_o`, `dout_o`, `reg_we_o` and `reg_re_o` are all zero.
- R2: A frame starts only on a cycle where `req_i` is high after being low, with the slave idle. On that first beat, `din_i[0]` is the operation flag (1 = write, 0 = read) and `din_i[1]` is address bit 0.
- R3: The next 8 beats carry address bits 1 to 16. Beat i (i = 1..8) has address bit 2i on `din_i[1]` and bit 2i-1 on `din_i[0]`. The captured address appears on `reg_addr_o` during the access.
- R4: A write frame lasts 9 + DATA_W/2 beats. Data beat k (k = 0..DATA_W/2-1) has data bit 2k+1 on `din_i[1]` and bit 2k on `din_i[0]`.
- R5: A completed write gives exactly one `reg_we_o` pulse, in the cycle after the last data beat, with the full address and data word on `reg_addr_o` and `reg_wdata_o`.
- R6: After a write, `ack_o` is high for exactly one cycle, the cycle after the `reg_we_o` pulse.
- R7: A read frame lasts 9 beats. Exactly one `reg_re_o` pulse follows, in the cycle after the last address beat, and `reg_rdata_i` is sampled in that cycle.
- R8: Starting the cycle after `reg_re_o`, the slave drives DATA_W/2 beats on `dout_o`. Beat k carries read-data bits 2k+1 (on bit 1) and 2k (on bit 0), and `ack_o` is high on every beat.
- R9: `dout_o` is zero whenever no read-data beat is being driven, including during a write acknowledge. `ack_o` is high only on read-data beats and on the single write acknowledge cycle.
- R10: If `req_i` falls before a frame's full beat count, the frame is dropped: no `reg_we_o`, no `reg_re_o` and no `ack_o` result from it.
- R11: A request that rises or stays high during a read response or a write acknowledge starts no frame. No extra access or acknowledge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, high for the length of a frame |
| din_i | input | 2 | Serial input lane, two bits per beat |
| ack_o | output | 1 | Acknowledge: write done, or read data beat valid |
| dout_o | output | 2 | Serial read data lane |
| reg_addr_o | output | 17 | Register address of the current access |
| reg_wdata_o | output | DATA_W | Assembled write data |
| reg_we_o | output | 1 | One-cycle register write enable |
| reg_re_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | DATA_W | Register read data, sampled with reg_re_o |

## Verification
The hardest case to reach from the ports is a request that arrives while the slave is still busy. Such a request must not start a frame, even though it is held until after the slave goes idle. The bench raises `req_i` in the first cycle of a read response or of a write acknowledge and keeps it high past the end. It then confirms that exactly one access occurred. Frames cut off at their first beat, their last address beat and their last data beat are aimed at directly. A random mix of operations, addresses, data words and cut-off points, from a fixed seed, covers the rest.

// File: rtl/sbus2_pkg.sv
package sbus2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RECV   = 3'd1,
    ST_ACCESS = 3'd2,
    ST_RESP   = 3'd3,
    ST_WACK   = 3'd4
  } sbus2_state_e;

  localparam int unsigned SBUS2_ADDR_W = 17;
endpackage

// File: rtl/sbus2_deser.sv
module sbus2_deser #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              first_i,
  input  logic              beat_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [1:0]        din_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned ABEATS = (ADDR_W - 1) / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (first_i) begin
      wr_o      <= din_i[0];
      addr_o[0] <= din_i[1];
    end else if (beat_i) begin
      if (int'(idx_i) <= ABEATS) begin
        addr_o[2*int'(idx_i)-1] <= din_i[0];
        addr_o[2*int'(idx_i)]   <= din_i[1];
      end else begin
        wdata_o[2*(int'(idx_i)-ABEATS-1) +: 2] <= din_i;
      end
    end
  end
endmodule

// File: rtl/sbus2_ser.sv
module sbus2_ser #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] par_i,
  output logic [1:0]        lane_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else if (shift_i) sh_q <= {2'b00, sh_q[DATA_W-1:2]};
  end

  assign lane_o = sh_q[1:0];
endmodule

// File: rtl/sbus2_ctrl.sv
module sbus2_ctrl
  import sbus2_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  output logic             first_o,
  output logic             beat_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             resp_o,
  output logic             we_o,
  output logic             re_o,
  output logic             ack_o
);
  localparam int unsigned RD_BEATS = 1 + (ADDR_W - 1) / 2;
  localparam int unsigned WR_BEATS = RD_BEATS + DATA_W / 2;
  localparam int unsigned RSP_BEATS = DATA_W / 2;

  sbus2_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = wr_i ? CNT_W'(WR_BEATS - 1) : CNT_W'(RD_BEATS - 1);

  assign first_o = (state_q == ST_IDLE) && req_i && !req_q;
  assign beat_o  = (state_q == ST_RECV) && req_i;
  assign idx_o   = cnt_q;
  assign we_o    = (state_q == ST_ACCESS) && wr_i;
  assign re_o    = (state_q == ST_ACCESS) && !wr_i;
  assign load_o  = re_o;
  assign resp_o  = (state_q == ST_RESP);
  assign shift_o = resp_o;
  assign ack_o   = resp_o || (state_q == ST_WACK);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (first_o) begin
        state_d = ST_RECV;
        cnt_d   = CNT_W'(1);
      end
      ST_RECV: begin
        if (!req_i) begin
          state_d = ST_IDLE;  // early drop discards frame
          cnt_d   = '0;
        end else if (cnt_q == last_idx) begin
          state_d = ST_ACCESS;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ACCESS: state_d = wr_i ? ST_WACK : ST_RESP;
      ST_RESP: begin
        if (cnt_q == CNT_W'(RSP_BEATS - 1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WACK: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      req_q   <= req_i;
    end
  end

  // R5
  we_re_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o));

  // R5
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  // R6
  wack_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (ack_o && !resp_o));

  // R8
  resp_after_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> (ack_o && resp_o));

  // R9
  ack_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(we_o) || $past(re_o)));

  // R10
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && !req_i) |=> (!we_o && !re_o && !ack_o));

  // R11
  busy_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !first_o);
endmodule

// File: rtl/sbus2_slave.sv
module sbus2_slave
  import sbus2_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [1:0]              din_i,
  output logic                    ack_o,
  output logic [1:0]              dout_o,
  output logic [SBUS2_ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0]       reg_wdata_o,
  output logic                    reg_we_o,
  output logic                    reg_re_o,
  input  logic [DATA_W-1:0]       reg_rdata_i
);
  localparam int unsigned ADDR_W = SBUS2_ADDR_W;
  localparam int unsigned TOTAL  = 1 + (ADDR_W - 1) / 2 + DATA_W / 2;
  localparam int unsigned CNT_W  = $clog2(TOTAL + 1);

  logic             first, beat, wr, load, shift, resp;
  logic [CNT_W-1:0] idx;
  logic [1:0]       lane;

  sbus2_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_i    (wr),
    .first_o (first),
    .beat_o  (beat),
    .idx_o   (idx),
    .load_o  (load),
    .shift_o (shift),
    .resp_o  (resp),
    .we_o    (reg_we_o),
    .re_o    (reg_re_o),
    .ack_o   (ack_o)
  );

  sbus2_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_i (first),
    .beat_i  (beat),
    .idx_i   (idx),
    .din_i   (din_i),
    .wr_o    (wr),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o)
  );

  sbus2_ser #(.DATA_W(DATA_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .par_i   (reg_rdata_i),
    .lane_o  (lane)
  );

  assign dout_o = resp ? lane : 2'b00;

  // R9
  dout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (dout_o == 2'b00));
endmodule

// File: tb/sbus2_slave_tb.sv
`timescale 1ns/1ps
module sbus2_slave_tb;
  localparam int DW     = 32;
  localparam int RD_LEN = 9;
  localparam int WR_LEN = 9 + DW/2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [1:0]    din_i = 2'b00;
  logic          ack_o;
  logic [1:0]    dout_o;
  logic [16:0]   reg_addr_o;
  logic [DW-1:0] reg_wdata_o;
  logic          reg_we_o, reg_re_o;
  logic [DW-1:0] reg_rdata_i;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rd_model(logic [16:0] a);
    logic [63:0] t;
    t = {a, a, a, a[12:0]} ^ 64'hA5C3_5A3C_9E17_61F0;
    return t[DW-1:0];
  endfunction

  assign reg_rdata_i = rd_model(reg_addr_o);

  sbus2_slave #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .din_i(din_i),
    .ack_o(ack_o), .dout_o(dout_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o), .reg_re_o(reg_re_o),
    .reg_rdata_i(reg_rdata_i)
  );

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] beat_val(bit wr, logic [16:0] a, logic [DW-1:0] d, int c);
    if (c == 0) return {a[0], wr};
    if (c <= 8) return {a[2*c], a[2*c-1]};
    return d[2*(c-9) +: 2];
  endfunction

  task automatic run_frame(bit wr, logic [16:0] a, logic [DW-1:0] d, int hold, bit intrude);
    int full, win, we_cnt, we_cyc, re_cnt, re_cyc, ack_cnt, ack_first, dout_bad, dout_nz;
    logic [16:0] we_a, re_a;
    logic [DW-1:0] we_d, rdx;
    bit done;
    full = wr ? WR_LEN : RD_LEN;
    done = (hold >= full);
    win = full + DW/2 + 10;
    rdx = rd_model(a);
    we_cnt = 0; we_cyc = -1; re_cnt = 0; re_cyc = -1; ack_cnt = 0; ack_first = -1;
    dout_bad = 0; dout_nz = 0; we_a = '0; re_a = '0; we_d = '0;
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (reg_we_o) begin we_cnt++; we_cyc = c; we_a = reg_addr_o; we_d = reg_wdata_o; end
      if (reg_re_o) begin re_cnt++; re_cyc = c; re_a = reg_addr_o; end
      if (ack_o) begin
        ack_cnt++;
        if (ack_first < 0) ack_first = c;
        if (wr) begin
          if (dout_o != 2'b00) dout_nz++;
        end else begin
          int k = c - (RD_LEN + 1);
          if (k < 0 || k >= DW/2 || dout_o != rdx[2*k +: 2]) dout_bad++;
        end
      end else if (dout_o != 2'b00) dout_nz++;
      if (c < hold && c < full) begin
        req_i = 1'b1; din_i = beat_val(wr, a, d, c);
      end else if (intrude && done && c >= full + 1 && c <= full + DW/2 + 3) begin
        req_i = 1'b1; din_i = 2'($urandom);
      end else begin
        req_i = 1'b0; din_i = 2'b00;
      end
    end
    if (!done) begin
      chk(we_cnt + re_cnt + ack_cnt == 0, "R10", "aborted frame activity", we_cnt + re_cnt + ack_cnt, 0);
    end else if (wr) begin
      chk(we_cnt == 1 && we_cyc == full, "R5", "write pulse cycle", we_cyc, full);
      chk(we_a == a, "R3", "write address (R2 A0)", we_a, a);
      chk(we_d == d, "R4", "write data", we_d, d);
      chk(ack_cnt == 1 && ack_first == full + 1, "R6", "write ack cycle/count", ack_cnt, 1);
      chk(re_cnt == 0 && dout_nz == 0, "R9", "stray read or dout", re_cnt + dout_nz, 0);
    end else begin
      chk(re_cnt == 1 && re_cyc == RD_LEN, "R7", "read strobe cycle", re_cyc, RD_LEN);
      chk(re_a == a, "R2", "read address (R3 pairs)", re_a, a);
      chk(ack_cnt == DW/2 && ack_first == RD_LEN + 1, "R8", "read ack beats", ack_cnt, DW/2);
      chk(dout_bad == 0, "R8", "read data beats", dout_bad, 0);
      chk(we_cnt == 0 && dout_nz == 0, "R9", "stray write or dout", we_cnt + dout_nz, 0);
    end
    if (intrude && done)
      chk(we_cnt + re_cnt == 1, "R11", "accesses with busy request", we_cnt + re_cnt, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2b17));
    repeat (3) @(negedge clk);
    chk(!ack_o && dout_o == 0 && !reg_we_o && !reg_re_o, "R1", "outputs in reset",
        {ack_o, dout_o, reg_we_o, reg_re_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ack_o && dout_o == 0 && !reg_we_o && !reg_re_o, "R1", "outputs after reset",
        {ack_o, dout_o, reg_we_o, reg_re_o}, 0);
    // directed corners
    run_frame(1'b1, 17'h1FFFF, '1, WR_LEN, 1'b0);
    run_frame(1'b0, 17'h00000, '0, RD_LEN, 1'b0);
    run_frame(1'b0, 17'h10001, '0, RD_LEN, 1'b0);
    run_frame(1'b1, 17'h0AAAA, DW'(32'h8000_0001), WR_LEN, 1'b0);
    run_frame(1'b1, 17'h01234, DW'(32'hDEAD_BEEF), 1, 1'b0);
    run_frame(1'b0, 17'h05678, '0, RD_LEN - 1, 1'b0);
    run_frame(1'b1, 17'h1ABCD, DW'(32'h1234_5678), WR_LEN - 1, 1'b0);
    run_frame(1'b0, 17'h0F0F0, '0, RD_LEN, 1'b1);
    run_frame(1'b1, 17'h13579, DW'(32'hCAFE_F00D), WR_LEN, 1'b1);
    run_frame(1'b1, 17'h02468, DW'(32'h0BAD_CAFE), WR_LEN, 1'b0);
    // constrained random
    for (int n = 0; n < 60; n++) begin
      bit wr = 1'($urandom);
      int full = wr ? WR_LEN : RD_LEN;
      int hold = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, full - 1)) : full;
      run_frame(wr, 17'($urandom), DW'($urandom), hold, ($urandom_range(0, 3) == 0));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule